// File: doc/BRIEF.md
# CAN Operating-Mode and Soft-Reset Control

This block is the register front end that decides in which operating mode a CAN protocol engine runs. Software reaches it over a plain 32-bit register port (address, write strobe, write data, read strobe, read data). Two words are held: a control word carrying an enable flag and a self-clearing reset command, and a mode-request word carrying loopback and sleep requests. From them the block keeps a four-state machine whose state is driven out as a one-hot mode vector to the protocol engine.

The machine has four states: ST_CONFIG, ST_LOOPBACK, ST_SLEEP and ST_NORMAL. From any state the transition is taken on the clock edge of the write that changes the registers: *disable* (enable cleared, or a reset command) leads to ST_CONFIG; *loop* (enable set, loopback requested) leads to ST_LOOPBACK; *doze* (enable set, only sleep requested) leads to ST_SLEEP; *run* (enable set, no request) leads to ST_NORMAL. When loopback and sleep are requested together, *loop* wins.

Bit numbering in register descriptions below uses the ordinary convention: bit 0 is the least significant bit of the data word.

Top module: `can_mode_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, and immediately while it is asserted, both registers read 0 and the mode vector is 4'b0001 (configuration).
- R2: The mode vector has exactly one of its four lines high: bit 0 configuration, bit 1 loopback, bit 2 sleep, bit 3 normal.
- R3: While the enable flag (control word bit 1) is 0, the mode is configuration whatever the mode-request word holds.
- R4: While enabled, the mode is normal when mode-request bits 1 (loopback) and 0 (sleep) are both 0, sleep when only bit 0 is set, loopback when bit 1 is set.
- R5: With enable set and both request bits set, the mode is loopback, never sleep.
- R6: A write to the control word with bit 0 set returns both registers, including enable and all other bits of that write, to 0, and the mode reads configuration in the next cycle.
- R7: Bit 0 of the control word always reads 0; bits 31..1 read back the last written value.
- R8: Bits 31..2 of the mode-request word are plain storage that reads back the last written value.
- R9: The mode vector changes on the clock edge that accepts the register write; it is unchanged before that edge.
- R10: Read data is registered: it presents the addressed word in the cycle after a read strobe and holds otherwise; an unmapped address reads 0.
- R11: The control word sits at address 0x00 and the mode-request word at 0x04; a write to any other address changes neither register nor the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| mode_onehot | output | 4 | One-hot operating mode to the protocol engine |

## Verification
A wrong internal state shows at the ports within one cycle: the mode vector is registered from the same next values that load the registers, so any error in write decode, reset command or priority appears on mode_onehot at the edge after the offending write. Stored bits that do not steer the mode (reserved bits, the enable copy) surface one cycle after a read strobe on reg_rdata. A stuck reset command or a lost priority therefore becomes visible no later than the second cycle after the write that exposes it.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

    localparam int unsigned MODE_LINES = 4;

    typedef enum logic [1:0] {
        ST_CONFIG   = 2'd0,
        ST_LOOPBACK = 2'd1,
        ST_SLEEP    = 2'd2,
        ST_NORMAL   = 2'd3
    } op_state_e;

    // Field positions inside the two words (LSB = bit 0)
    localparam int unsigned CTL_RST_BIT = 0;
    localparam int unsigned CTL_EN_BIT  = 1;
    localparam int unsigned REQ_SLP_BIT = 0;
    localparam int unsigned REQ_LB_BIT  = 1;

endpackage

// File: rtl/can_ctl_regs.sv
module can_ctl_regs #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CTL_OFFS  = 0,
    parameter int unsigned REQ_OFFS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              en_nxt,
    output logic              lb_nxt,
    output logic              slp_nxt,
    output logic              en_cur,
    output logic              lb_cur,
    output logic              slp_cur,
    output logic              sw_rst
);
    import can_mode_pkg::*;

    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFFS);
    localparam logic [ADDR_W-1:0] REQ_A = ADDR_W'(REQ_OFFS);

    // control word keeps bits DATA_W-1..1; bit 0 is a command, not storage
    logic [DATA_W-1:1] ctl_q, ctl_d;
    logic [DATA_W-1:0] req_q, req_d;
    logic [DATA_W-1:0] rdata_q, rsel;
    logic              hit_ctl, hit_req;

    assign hit_ctl = reg_wr && (reg_addr == CTL_A);
    assign hit_req = reg_wr && (reg_addr == REQ_A);
    assign sw_rst  = hit_ctl && reg_wdata[CTL_RST_BIT];

    always_comb begin
        ctl_d = ctl_q;
        req_d = req_q;
        if (sw_rst) begin
            ctl_d = '0;
            req_d = '0;
        end else begin
            if (hit_ctl) ctl_d = reg_wdata[DATA_W-1:1];
            if (hit_req) req_d = reg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            req_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            req_q <= req_d;
        end
    end

    always_comb begin
        if (reg_addr == CTL_A)      rsel = {ctl_q, 1'b0};
        else if (reg_addr == REQ_A) rsel = req_q;
        else                        rsel = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (reg_rd) rdata_q <= rsel;
    end

    assign reg_rdata = rdata_q;
    assign en_nxt    = ctl_d[CTL_EN_BIT];
    assign lb_nxt    = req_d[REQ_LB_BIT];
    assign slp_nxt   = req_d[REQ_SLP_BIT];
    assign en_cur    = ctl_q[CTL_EN_BIT];
    assign lb_cur    = req_q[REQ_LB_BIT];
    assign slp_cur   = req_q[REQ_SLP_BIT];

endmodule

// File: rtl/can_mode_fsm.sv
module can_mode_fsm (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                en_nxt,
    input  logic                                lb_nxt,
    input  logic                                slp_nxt,
    output logic [can_mode_pkg::MODE_LINES-1:0] mode_onehot
);
    import can_mode_pkg::*;

    op_state_e state_q, state_d;

    // transitions: disable / loop / doze / run
    always_comb begin
        if (!en_nxt)      state_d = ST_CONFIG;
        else if (lb_nxt)  state_d = ST_LOOPBACK;
        else if (slp_nxt) state_d = ST_SLEEP;
        else              state_d = ST_NORMAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CONFIG;
        else        state_q <= state_d;
    end

    always_comb begin
        mode_onehot = '0;
        unique case (state_q)
            ST_CONFIG:   mode_onehot[0] = 1'b1;
            ST_LOOPBACK: mode_onehot[1] = 1'b1;
            ST_SLEEP:    mode_onehot[2] = 1'b1;
            ST_NORMAL:   mode_onehot[3] = 1'b1;
            default:     mode_onehot    = '0;
        endcase
    end

endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CTL_OFFS = 0,
    parameter int unsigned REQ_OFFS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [3:0]        mode_onehot
);
    logic en_nxt, lb_nxt, slp_nxt;
    logic en_cur, lb_cur, slp_cur;
    logic sw_rst;

    can_ctl_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .CTL_OFFS(CTL_OFFS), .REQ_OFFS(REQ_OFFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .en_nxt(en_nxt), .lb_nxt(lb_nxt), .slp_nxt(slp_nxt),
        .en_cur(en_cur), .lb_cur(lb_cur), .slp_cur(slp_cur),
        .sw_rst(sw_rst)
    );

    can_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .en_nxt(en_nxt), .lb_nxt(lb_nxt), .slp_nxt(slp_nxt),
        .mode_onehot(mode_onehot)
    );

endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned CTL_OFFS = 0,
    parameter int unsigned REQ_OFFS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [3:0]        mode_onehot,
    input logic              en_cur,
    input logic              lb_cur,
    input logic              slp_cur
);
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFFS);
    localparam logic [ADDR_W-1:0] REQ_A = ADDR_W'(REQ_OFFS);

    // R2
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mode_onehot) == 1);

    // R6
    soft_rst_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == CTL_A && reg_wdata[0]) |=> (mode_onehot == 4'b0001 && !en_cur && !lb_cur && !slp_cur));

    // R3
    disabled_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_cur) |-> (mode_onehot == 4'b0001));

    // R5
    lb_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_cur && lb_cur) |-> (mode_onehot == 4'b0010));

    // R4
    sleep_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_cur && !lb_cur && slp_cur) |-> (mode_onehot == 4'b0100));

    // R7
    rst_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == CTL_A) |=> (reg_rdata[0] == 1'b0));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd) |=> $stable(reg_rdata));

    // R11
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr != CTL_A && reg_addr != REQ_A) |=> $stable(mode_onehot));

endmodule

bind can_mode_ctrl can_mode_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_OFFS(CTL_OFFS), .REQ_OFFS(REQ_OFFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .mode_onehot(mode_onehot), .en_cur(en_cur), .lb_cur(lb_cur), .slp_cur(slp_cur)
);

// File: tb/sim_can_mode_ctrl.sv
module sim_can_mode_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic [3:0]  mode_onehot;

    int applied = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [3:0] M_CFG = 4'b0001, M_LB = 4'b0010, M_SLP = 4'b0100, M_NRM = 4'b1000;

    // {request word, control word, expected mode}
    localparam logic [67:0] VECS [8] = '{
        {32'h0000_0000, 32'h0000_0000, M_CFG},
        {32'h0000_0001, 32'h0000_0000, M_CFG},
        {32'h0000_0000, 32'h0000_0002, M_NRM},
        {32'h0000_0001, 32'h0000_0002, M_SLP},
        {32'h0000_0002, 32'h0000_0002, M_LB },
        {32'h0000_0003, 32'h0000_0002, M_LB },
        {32'hA5A5_0003, 32'h1234_5602, M_LB },
        {32'hFFFF_FFFD, 32'hFFFF_FFFC, M_CFG}
    };

    always #2.5 clk = ~clk;

    can_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .mode_onehot(mode_onehot)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            applied++; bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        #12;
        // R1 during reset
        check("R1", {28'd0, mode_onehot}, {28'd0, M_CFG});
        @(negedge clk); rst_n = 1'b1;
        rd(8'h00, v); check("R1", v, 32'h0);
        rd(8'h04, v); check("R1", v, 32'h0);
        check("R1", {28'd0, mode_onehot}, {28'd0, M_CFG});

        // R2 R3 R4 R5 R7 R8 vector table
        for (int i = 0; i < 8; i++) begin
            wr(8'h04, VECS[i][67:36]);
            wr(8'h00, VECS[i][35:4]);
            check("R2/R3/R4/R5", {28'd0, mode_onehot}, {28'd0, VECS[i][3:0]});
            rd(8'h00, v); check("R7", v, VECS[i][35:4] & 32'hFFFF_FFFE);
            rd(8'h04, v); check("R8", v, VECS[i][67:36]);
        end

        // R9 timing of mode change
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h2);
        check("R9", {28'd0, mode_onehot}, {28'd0, M_NRM});
        @(negedge clk);
        reg_addr = 8'h04; reg_wdata = 32'h2; reg_wr = 1'b1;
        #1 check("R9", {28'd0, mode_onehot}, {28'd0, M_NRM});
        @(negedge clk); reg_wr = 1'b0;
        check("R9", {28'd0, mode_onehot}, {28'd0, M_LB});

        // R6 soft reset with every other bit set
        wr(8'h04, 32'hFFFF_FFFE);
        wr(8'h00, 32'hFFFF_FFFF);
        check("R6", {28'd0, mode_onehot}, {28'd0, M_CFG});
        rd(8'h00, v); check("R6", v, 32'h0);
        rd(8'h04, v); check("R6", v, 32'h0);

        // R11 unmapped write
        wr(8'h00, 32'h2);
        wr(8'h04, 32'h1);
        wr(8'h08, 32'hFFFF_FFFF);
        check("R11", {28'd0, mode_onehot}, {28'd0, M_SLP});
        rd(8'h00, v); check("R11", v, 32'h2);
        rd(8'h04, v); check("R11", v, 32'h1);

        // R10 unmapped read and hold
        rd(8'h08, v); check("R10", v, 32'h0);
        rd(8'h04, v);
        wr(8'h04, 32'h5A00_0000);
        check("R10", reg_rdata, 32'h1);

        // R1 asynchronous reset mid-run
        check("R1", {28'd0, mode_onehot}, {28'd0, M_NRM});
        @(negedge clk); #1 rst_n = 1'b0;
        #0.5 check("R1", {28'd0, mode_onehot}, {28'd0, M_CFG});
        check("R1", reg_rdata, 32'h0);
        @(negedge clk); rst_n = 1'b1;
        rd(8'h04, v); check("R1", v, 32'h0);

        done = 1'b1;
        summary();
    end
endmodule